// File: doc/BRIEF.md
# Secure Scan Flush and Substitute-Key Controller

This controller sits between a test-instruction decoder and the scan chains of a cryptographic core. While the chip runs in mission mode, the scan output pins carry only zeros and the core receives the user key. When the decoder reports the secure scan-test instruction, the controller takes over. It lets the chains shift a counted number of times while their serial outputs stay forced to zero, so that any secret data left in the chain registers is pushed out and never seen. After that it opens the output gate. From the first cycle of the instruction onwards, a constant substitute key is steered into the core's key port in place of the user key.

Once the secure instruction has been seen, only a reset brings the user key back. If the instruction drops, the gate closes at once and the flush count is discarded. The next time the instruction is applied, the chain must be flushed again in full before any data can be observed.

Top module: `scan_flush_guard`

## Requirements
- R1: While rst_n is low, gated_so is all zeros, key_sel_fake is 0 and core_key equals user_key, whatever the other inputs are.
- R2: After reset and before the secure instruction is first sampled high, gated_so stays all zeros for any chain_so, and core_key follows user_key.
- R3: On the first clock edge where secure_instr is sampled high, key_sel_fake goes to 1 and core_key becomes FAKE_KEY.
- R4: While the instruction is held, gated_so stays zero until CHAIN_LEN clock edges have sampled shift_en high. Edges where shift_en is low do not count, and neither do edges where secure_instr is low.
- R5: From the cycle after the edge that samples the CHAIN_LEN-th counted shift, gated_so equals chain_so combinationally, lane by lane.
- R6: With the gate open and secure_instr held, the gate stays open whatever shift_en does.
- R7: On the edge after secure_instr is sampled low, the gate closes and the flush count is discarded. key_sel_fake stays 1 until reset.
- R8: After the instruction is dropped and applied again, the gate opens only after a fresh, complete run of CHAIN_LEN counted shifts.
- R9: A reset asserted at any point returns the block to the state of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| secure_instr | input | 1 | Decoded secure scan-test instruction is active |
| shift_en | input | 1 | Scan shift enable for this cycle |
| chain_so | input | LANES | Raw serial outputs of the scan chains |
| user_key | input | KEY_W | Key from secure storage |
| gated_so | output | LANES | Scan outputs after the gate |
| key_sel_fake | output | 1 | High while the substitute key is selected |
| core_key | output | KEY_W | Key delivered to the core |

## Verification
Every result of this block becomes due one clock edge after the inputs that cause it. The key switch appears after the first edge that samples the instruction high. The gate opens after the edge that samples the last counted shift, and it closes after the edge that samples the instruction low. The gate and key multiplexers are combinational after those registers. For that reason the bench drives its inputs on the falling edge, updates its reference model only on the rising edge, and compares 1 ns after each drive. Each comparison therefore sees the state left by the last rising edge, combined with the current inputs.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      SG_NORMAL = 2'd0,
      SG_FLUSH  = 2'd1,
      SG_TEST   = 2'd2,
      SG_LOCKED = 2'd3
   } sg_mode_e;
endpackage

// File: rtl/sg_flush_counter.sv
module sg_flush_counter #(
   parameter int CHAIN_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam int CW = (CHAIN_LEN < 2) ? 1 : $clog2(CHAIN_LEN);
   localparam logic [CW-1:0] LAST_VAL = CW'(CHAIN_LEN - 1);

   logic [CW-1:0] cnt_q;

   // high on the shift that completes the flush
   assign last = step && (cnt_q == LAST_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sg_mode_fsm.sv
module sg_mode_fsm
   import sg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic secure_instr,
   input  logic shift_en,
   input  logic flush_last,
   output logic cnt_step,
   output logic cnt_clear,
   output logic gate_open,
   output logic fake_sel
);
   sg_mode_e state_q, state_d;

   assign cnt_clear = !secure_instr;
   assign cnt_step  = secure_instr && shift_en && (state_q != SG_TEST);
   assign gate_open = (state_q == SG_TEST);
   assign fake_sel  = (state_q != SG_NORMAL);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SG_NORMAL, SG_LOCKED: begin
            if (secure_instr) state_d = flush_last ? SG_TEST : SG_FLUSH;
         end
         SG_FLUSH: begin
            if (!secure_instr)   state_d = SG_LOCKED;
            else if (flush_last) state_d = SG_TEST;
         end
         SG_TEST: begin
            if (!secure_instr) state_d = SG_LOCKED;
         end
         default: state_d = SG_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SG_NORMAL;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/sg_scan_gate.sv
module sg_scan_gate #(
   parameter int LANES   = 2,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic [LANES-1:0] raw_so,
   output logic [LANES-1:0] out_so
);
   logic [LANES-1:0] masked;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign masked[i] = raw_so[i] & open;
   end

   if (OUT_REG) begin : g_reg
      logic [LANES-1:0] so_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) so_q <= '0;
         else        so_q <= masked;
      end
      assign out_so = so_q;
   end else begin : g_comb
      assign out_so = masked;
   end
endmodule

// File: rtl/sg_key_mux.sv
module sg_key_mux #(
   parameter int               KEY_W    = 32,
   parameter logic [KEY_W-1:0] FAKE_KEY = '0
) (
   input  logic             use_fake,
   input  logic [KEY_W-1:0] user_key,
   output logic [KEY_W-1:0] core_key
);
   assign core_key = use_fake ? FAKE_KEY : user_key;
endmodule

// File: rtl/scan_flush_guard.sv
module scan_flush_guard #(
   parameter int               CHAIN_LEN = 16,
   parameter int               LANES     = 2,
   parameter int               KEY_W     = 32,
   parameter logic [KEY_W-1:0] FAKE_KEY  = 32'h5A3C_96E1,
   parameter bit               OUT_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             secure_instr,
   input  logic             shift_en,
   input  logic [LANES-1:0] chain_so,
   input  logic [KEY_W-1:0] user_key,
   output logic [LANES-1:0] gated_so,
   output logic             key_sel_fake,
   output logic [KEY_W-1:0] core_key
);
   if (CHAIN_LEN < 1) begin : g_bad_len
      $error("scan_flush_guard: CHAIN_LEN must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("scan_flush_guard: LANES must be at least 1");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("scan_flush_guard: KEY_W must be at least 1");
   end

   logic flush_last;
   logic cnt_step;
   logic cnt_clear;
   logic gate_open_w;
   logic fake_sel_w;

   sg_flush_counter #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cnt_clear),
      .step  (cnt_step),
      .last  (flush_last)
   );

   sg_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .secure_instr (secure_instr),
      .shift_en     (shift_en),
      .flush_last   (flush_last),
      .cnt_step     (cnt_step),
      .cnt_clear    (cnt_clear),
      .gate_open    (gate_open_w),
      .fake_sel     (fake_sel_w)
   );

   sg_scan_gate #(.LANES(LANES), .OUT_REG(OUT_REG)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .open   (gate_open_w),
      .raw_so (chain_so),
      .out_so (gated_so)
   );

   sg_key_mux #(.KEY_W(KEY_W), .FAKE_KEY(FAKE_KEY)) u_key (
      .use_fake (fake_sel_w),
      .user_key (user_key),
      .core_key (core_key)
   );

   assign key_sel_fake = fake_sel_w;
endmodule

// File: rtl/sg_guard_checker.sv
module sg_guard_checker #(
   parameter int CHAIN_LEN = 16,
   parameter int LANES     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             secure_instr,
   input logic             shift_en,
   input logic             gate_open,
   input logic             key_sel_fake,
   input logic [LANES-1:0] gated_so
);
   localparam int KW = $clog2(CHAIN_LEN + 1) + 1;
   logic [KW-1:0] seen_q;

   // independent tally of shifts sampled while the instruction is held and the gate is closed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      seen_q <= '0;
      else if (!secure_instr)          seen_q <= '0;
      else if (shift_en && !gate_open) seen_q <= seen_q + 1'b1;
   end

   a_r2_normal_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !key_sel_fake |-> (gated_so == '0));

   a_r3_enter_fake: assert property (@(posedge clk) disable iff (!rst_n)
      (secure_instr && !key_sel_fake) |=> key_sel_fake);

   a_r4_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
      gate_open |-> (seen_q == KW'(CHAIN_LEN)));

   a_r5_open_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_open) |-> $past(shift_en));

   a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && secure_instr) |=> gate_open);

   a_r7_drop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      !secure_instr |=> !gate_open);

   a_r7_fake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      key_sel_fake |=> key_sel_fake);
endmodule

bind scan_flush_guard sg_guard_checker #(.CHAIN_LEN(CHAIN_LEN), .LANES(LANES)) u_guard_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .secure_instr (secure_instr),
   .shift_en     (shift_en),
   .gate_open    (gate_open_w),
   .key_sel_fake (key_sel_fake),
   .gated_so     (gated_so)
);

// File: tb/scan_flush_guard_test.sv
`timescale 1ns/1ps
module scan_flush_guard_test;
   localparam int               CHAIN_LEN = 16;
   localparam int               LANES     = 2;
   localparam int               KEY_W     = 32;
   localparam logic [KEY_W-1:0] FAKE      = 32'h5A3C_96E1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             secure_instr = 1'b0;
   logic             shift_en = 1'b0;
   logic [LANES-1:0] chain_so = '0;
   logic [KEY_W-1:0] user_key = '0;
   logic [LANES-1:0] gated_so;
   logic             key_sel_fake;
   logic [KEY_W-1:0] core_key;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   // reference model state
   int  m_cnt  = 0;
   bit  m_fake = 1'b0;
   bit  m_open = 1'b0;

   always #4 clk = ~clk;

   scan_flush_guard #(
      .CHAIN_LEN(CHAIN_LEN), .LANES(LANES), .KEY_W(KEY_W),
      .FAKE_KEY(FAKE), .OUT_REG(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .secure_instr(secure_instr), .shift_en(shift_en),
      .chain_so(chain_so), .user_key(user_key), .gated_so(gated_so),
      .key_sel_fake(key_sel_fake), .core_key(core_key)
   );

   task automatic cmp(input string req, input string what,
                      input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic r, input logic ins, input logic sh,
                       input logic [LANES-1:0] so, input logic [KEY_W-1:0] uk,
                       input string req);
      @(negedge clk);
      rst_n = r; secure_instr = ins; shift_en = sh; chain_so = so; user_key = uk;
      if (!r) begin m_cnt = 0; m_fake = 1'b0; m_open = 1'b0; end
      #1;
      cmp(req, "gated_so", KEY_W'(gated_so), KEY_W'(m_open ? so : '0));
      cmp(req, "key_sel_fake", KEY_W'(key_sel_fake), KEY_W'(m_fake));
      cmp(req, "core_key", core_key, m_fake ? FAKE : uk);
      @(posedge clk);
      if (r) begin
         if (!ins) begin
            m_cnt = 0; m_open = 1'b0;
         end else begin
            m_fake = 1'b1;
            if (!m_open && sh) begin
               m_cnt++;
               if (m_cnt == CHAIN_LEN) m_open = 1'b1;
            end
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int k;
      // R1: reset state, even with the instruction requested
      step(0, 0, 0, 2'b11, 32'hAAAA_0001, "R1");
      step(0, 1, 1, 2'b11, 32'hAAAA_0002, "R1");
      step(0, 0, 1, 2'b10, 32'hAAAA_0003, "R1");

      // R2: normal mode blocks output and passes the user key
      for (int i = 0; i < 6; i++)
         step(1, 0, i[0], 2'b11 ^ LANES'(i), 32'h1000_0000 + i, "R2");

      // R3: first edge with the instruction selects the substitute key
      step(1, 1, 0, 2'b11, 32'h2000_0001, "R3");
      step(1, 1, 0, 2'b11, 32'h2000_0002, "R3");

      // R4: flush with gaps in shift_en; output held at zero until the count completes
      k = 0;
      while (!m_open && k < 200) begin
         step(1, 1, (k % 3) != 0, 2'b11, 32'h3000_0000 + k, "R4");
         k++;
      end

      // R5: gate now passes every lane pattern
      for (int i = 0; i < 4; i++)
         step(1, 1, 1, LANES'(i), 32'h4000_0000 + i, "R5");

      // R6: gate stays open with shift_en low
      for (int i = 0; i < 4; i++)
         step(1, 1, 0, LANES'(3 - i), 32'h5000_0000 + i, "R6");

      // R7: dropping the instruction closes the gate, key stays substituted
      for (int i = 0; i < 4; i++)
         step(1, 0, i[0], 2'b11, 32'h6000_0000 + i, "R7");

      // R8: partial flush, drop, then a full fresh flush is needed
      for (int i = 0; i < 5; i++)
         step(1, 1, 1, 2'b11, 32'h7000_0000 + i, "R8");
      step(1, 0, 1, 2'b11, 32'h7000_0100, "R8");
      k = 0;
      while (!m_open && k < 200) begin
         step(1, 1, 1, 2'b11, 32'h7100_0000 + k, "R8");
         k++;
      end
      step(1, 1, 1, 2'b01, 32'h7200_0000, "R5");
      step(1, 1, 0, 2'b10, 32'h7200_0001, "R6");

      // R9: reset mid-test restores normal mode and the user key
      step(0, 1, 1, 2'b11, 32'h8000_0001, "R9");
      step(1, 0, 1, 2'b11, 32'h8000_0002, "R9");
      step(1, 0, 0, 2'b11, 32'h8000_0003, "R9");

      // R4: shifts during normal mode before entry do not count
      for (int i = 0; i < 3; i++)
         step(1, 0, 1, 2'b11, 32'h9000_0000 + i, "R4");
      k = 0;
      while (!m_open && k < 200) begin
         step(1, 1, k[0], 2'b11, 32'h9100_0000 + k, "R4");
         k++;
      end
      step(1, 1, 0, 2'b11, 32'h9200_0000, "R5");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule